// File: doc/BRIEF.md
# Shift and Bitwise Logic Execution Unit

This unit is the bitwise and shift slice of a register machine's execution stage. Each cycle it takes a 2-bit group select, a 4-bit function code and two operands, `opb` and `opc`. One clock edge later it presents the result on `res`, together with a flag that marks a function code that has no meaning. The operand width is a parameter. The unit never sees a full instruction word. The decode stage hands it only the group and the function code.

Group 0 covers ten two-input Boolean functions. They are the usual conjunction, disjunction and exclusive families, their complements, and all four implication and nonimplication forms. Group 1 shifts or rotates `opb` by the unsigned amount held in `opc`. The fill forms are arithmetic, zeros and ones, and rotation is circular. Fill shifts saturate once the count reaches the operand width. Rotation counts wrap modulo the width.

Top module: `bitshift_unit`

## Requirements
- R1: While `rst` is high, `res` and `illegal` read zero at every following clock edge. Otherwise each result reflects the inputs sampled at the previous rising edge of `clk`.
- R2: With group 0, codes 0 to 5 return `opb` AND, OR, XOR, NAND, NOR and XNOR `opc`, in that code order.
- R3: With group 0, code 6 returns `~opb & opc` and code 7 returns `opb & ~opc`.
- R4: With group 0, code 8 returns `~opb | opc` and code 9 returns `opb | ~opc`.
- R5: With group 1, code 0 shifts `opb` left by `opc` with zeros entering from the bottom. Code 1 shifts right with copies of the sign bit entering from the top. A count of W or more gives all zeros for code 0 and all sign bits for code 1.
- R6: With group 1, codes 2 and 3 shift left and right with zeros filling the vacated bits. A count of W or more gives zero.
- R7: With group 1, codes 4 and 5 shift left and right with ones filling the vacated bits. A count of W or more gives all ones.
- R8: With group 1, code 6 rotates `opb` left and code 7 rotates it right by `opc` modulo W positions.
- R9: Reserved selections give `res` = 0 and `illegal` = 1. These are group 0 with codes 10 to 15, group 1 with codes 8 to 15, and group values 2 and 3 with any code.
- R10: Every selection not listed in R9 gives `illegal` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| grp | input | 2 | Group select: 0 logic, 1 shift/rotate, 2 and 3 reserved |
| fn | input | 4 | Function code within the group |
| opb | input | W | First operand; the value shifted or rotated |
| opc | input | W | Second operand; the unsigned count for group 1 |
| res | output | W | Registered result |
| illegal | output | 1 | Registered flag for a reserved selection |

## Verification
The hardest behaviour to reach is at the edge of the count range. The saturating fill shifts must switch from a partial shift to a full fill exactly at a count of W. Counts of W, W+1, 2W and all ones must also wrap correctly for the rotates. The stimulus therefore sweeps every count from 0 up past W, adds two far-out counts, and applies each count to a spread of operand values. The operands include both sign polarities, which exercises the arithmetic right fill. Every one of the 64 group/code pairs is driven, so every reserved slot gets checked as well.

// File: rtl/bitshift_pkg.sv
package bitshift_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_SHIFT = 2'd1
  } grp_e;

  typedef enum logic [3:0] {
    LF_AND  = 4'd0,
    LF_OR   = 4'd1,
    LF_XOR  = 4'd2,
    LF_NAND = 4'd3,
    LF_NOR  = 4'd4,
    LF_XNOR = 4'd5,
    LF_CNIM = 4'd6,
    LF_MNIM = 4'd7,
    LF_MIMP = 4'd8,
    LF_CIMP = 4'd9
  } logic_fn_e;

  typedef enum logic [3:0] {
    SF_ASL = 4'd0,
    SF_ASR = 4'd1,
    SF_ZSL = 4'd2,
    SF_ZSR = 4'd3,
    SF_OSL = 4'd4,
    SF_OSR = 4'd5,
    SF_ROL = 4'd6,
    SF_ROR = 4'd7
  } shift_fn_e;

endpackage

// File: rtl/bitshift_logic.sv
module bitshift_logic
  import bitshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  output logic [W-1:0] y,
  output logic         bad
);

  always_comb begin
    bad = 1'b0;
    unique case (fn)
      LF_AND:  y = opb & opc;
      LF_OR:   y = opb | opc;
      LF_XOR:  y = opb ^ opc;
      LF_NAND: y = ~(opb & opc);
      LF_NOR:  y = ~(opb | opc);
      LF_XNOR: y = ~(opb ^ opc);
      LF_CNIM: y = ~opb & opc;
      LF_MNIM: y = opb & ~opc;
      LF_MIMP: y = ~opb | opc;
      LF_CIMP: y = opb | ~opc;
      default: begin
        y   = '0;
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bitshift_barrel.sv
module bitshift_barrel
  import bitshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   fn,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  output logic [W-1:0] y,
  output logic         bad
);

  localparam int CW = $clog2(W);
  localparam logic [W-1:0] W_VAL = W[W-1:0];
  localparam bit POW2 = ((W & (W - 1)) == 0);

  logic          over;
  logic [CW-1:0] amt;
  logic [CW-1:0] rot_amt;
  logic          fill_l;
  logic          fill_r;

  assign over = (opc >= W_VAL);
  assign amt  = opc[CW-1:0];

  generate
    if (POW2) begin : g_rot_pow2
      assign rot_amt = opc[CW-1:0];
    end else begin : g_rot_mod
      assign rot_amt = CW'(opc % W_VAL);
    end
  endgenerate

  always_comb begin
    fill_l = (fn == SF_OSL);
    unique case (fn)
      SF_ASR:  fill_r = opb[W-1];
      SF_OSR:  fill_r = 1'b1;
      default: fill_r = 1'b0;
    endcase
  end

  logic [W-1:0] lsh [0:CW];
  logic [W-1:0] rsh [0:CW];
  logic [W-1:0] rol [0:CW];
  logic [W-1:0] ror [0:CW];

  assign lsh[0] = opb;
  assign rsh[0] = opb;
  assign rol[0] = opb;
  assign ror[0] = opb;

  generate
    for (genvar s = 0; s < CW; s++) begin : g_stage
      localparam int S = 1 << s;
      assign lsh[s+1] = amt[s]     ? {lsh[s][W-1-S:0], {S{fill_l}}}    : lsh[s];
      assign rsh[s+1] = amt[s]     ? {{S{fill_r}}, rsh[s][W-1:S]}      : rsh[s];
      assign rol[s+1] = rot_amt[s] ? {rol[s][W-1-S:0], rol[s][W-1:W-S]} : rol[s];
      assign ror[s+1] = rot_amt[s] ? {ror[s][S-1:0], ror[s][W-1:S]}    : ror[s];
    end
  endgenerate

  always_comb begin
    bad = 1'b0;
    unique case (fn)
      SF_ASL, SF_ZSL, SF_OSL: y = over ? {W{fill_l}} : lsh[CW];
      SF_ASR, SF_ZSR, SF_OSR: y = over ? {W{fill_r}} : rsh[CW];
      SF_ROL:                 y = rol[CW];
      SF_ROR:                 y = ror[CW];
      default: begin
        y   = '0;
        bad = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
  import bitshift_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   grp,
  input  logic [3:0]   fn,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] opc,
  output logic [W-1:0] res,
  output logic         illegal
);

  logic [W-1:0] log_y;
  logic         log_bad;
  logic [W-1:0] sh_y;
  logic         sh_bad;
  logic [W-1:0] nxt_y;
  logic         nxt_bad;

  bitshift_logic #(.W(W)) u_logic (
    .fn  (fn),
    .opb (opb),
    .opc (opc),
    .y   (log_y),
    .bad (log_bad)
  );

  bitshift_barrel #(.W(W)) u_barrel (
    .fn  (fn),
    .opb (opb),
    .opc (opc),
    .y   (sh_y),
    .bad (sh_bad)
  );

  always_comb begin
    unique case (grp)
      GRP_LOGIC: begin
        nxt_y   = log_y;
        nxt_bad = log_bad;
      end
      GRP_SHIFT: begin
        nxt_y   = sh_y;
        nxt_bad = sh_bad;
      end
      default: begin
        nxt_y   = '0;
        nxt_bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      illegal <= 1'b0;
    end else begin
      res     <= nxt_y;
      illegal <= nxt_bad;
    end
  end

endmodule

// File: rtl/bitshift_unit_chk.sv
module bitshift_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   grp,
  input logic [3:0]   fn,
  input logic [W-1:0] opb,
  input logic [W-1:0] opc,
  input logic [W-1:0] res,
  input logic         illegal
);

  localparam logic [W-1:0] W_VAL = W[W-1:0];

  logic rsv;
  assign rsv = grp[1] || (grp == 2'd0 && fn >= 4'd10) || (grp == 2'd1 && fn >= 4'd8);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res == '0 && !illegal));

  a_r2_and: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd0 && fn == 4'd0) |=> (res == ($past(opb) & $past(opc))));

  a_r3_cnim: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd0 && fn == 4'd6) |=> (res == (~$past(opb) & $past(opc))));

  a_r4_mimp: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd0 && fn == 4'd8) |=> (res == (~$past(opb) | $past(opc))));

  a_r5_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd1 && fn == 4'd1 && opc >= W_VAL) |=> (res == {W{$past(opb[W-1])}}));

  a_r6_zero_sat: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd1 && fn == 4'd3 && opc >= W_VAL) |=> (res == '0));

  a_r7_ones_sat: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd1 && fn == 4'd4 && opc >= W_VAL) |=> (res == '1));

  a_r8_rot_zero: assert property (@(posedge clk) disable iff (rst)
    (grp == 2'd1 && (fn == 4'd6 || fn == 4'd7) && opc == '0) |=> (res == $past(opb)));

  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    rsv |=> (illegal && res == '0));

  a_r10_legal: assert property (@(posedge clk) disable iff (rst)
    !rsv |=> !illegal);

endmodule

bind bitshift_unit bitshift_unit_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .grp     (grp),
  .fn      (fn),
  .opb     (opb),
  .opc     (opc),
  .res     (res),
  .illegal (illegal)
);

// File: tb/bitshift_unit_test.sv
module bitshift_unit_test;

  localparam int W = 8;
  localparam time HALF = 10ns;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   grp = '0;
  logic [3:0]   fn  = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] opc = '0;
  logic [W-1:0] res;
  logic         illegal;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(HALF) clk = ~clk;

  bitshift_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .grp(grp), .fn(fn),
    .opb(opb), .opc(opc), .res(res), .illegal(illegal)
  );

  function automatic string tag_of(input int g, input int f);
    if (g >= 2) return "R9";
    if (g == 0) begin
      if (f <= 5) return "R2";
      if (f <= 7) return "R3";
      if (f <= 9) return "R4";
      return "R9";
    end
    if (f <= 1) return "R5";
    if (f <= 3) return "R6";
    if (f <= 5) return "R7";
    if (f <= 7) return "R8";
    return "R9";
  endfunction

  // Reference model, bit by bit from the requirement text
  function automatic logic [W:0] model(input int g, input int f,
                                       input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W-1:0] y;
    int cnt;
    int k;
    logic fl;
    y   = '0;
    cnt = int'(c);
    if (g == 0 && f <= 9) begin
      for (int i = 0; i < W; i++) begin
        case (f)
          0: y[i] = b[i] & c[i];
          1: y[i] = b[i] | c[i];
          2: y[i] = b[i] ^ c[i];
          3: y[i] = !(b[i] & c[i]);
          4: y[i] = !(b[i] | c[i]);
          5: y[i] = !(b[i] ^ c[i]);
          6: y[i] = !b[i] & c[i];
          7: y[i] = b[i] & !c[i];
          8: y[i] = !b[i] | c[i];
          default: y[i] = b[i] | !c[i];
        endcase
      end
      return {1'b0, y};
    end
    if (g == 1 && f <= 7) begin
      if (f == 6 || f == 7) begin
        k = cnt % W;
        for (int i = 0; i < W; i++)
          y[i] = (f == 6) ? b[(i - k + W) % W] : b[(i + k) % W];
        return {1'b0, y};
      end
      if (f == 1)      fl = b[W-1];
      else if (f >= 4) fl = 1'b1;
      else             fl = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (f % 2 == 0) y[i] = (cnt >= W || i - cnt < 0)  ? fl : b[i - cnt];
        else            y[i] = (cnt >= W || i + cnt >= W) ? fl : b[i + cnt];
      end
      return {1'b0, y};
    end
    return {1'b1, {W{1'b0}}};
  endfunction

  task automatic apply(input int g, input int f, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [W:0] e;
    @(negedge clk);
    grp = 2'(g); fn = 4'(f); opb = b; opc = c;
    e = model(g, f, b, c);
    @(negedge clk);
    n_vec++;
    if (res !== e[W-1:0] || illegal !== e[W]) begin
      n_fail++;
      $display("FAIL %s grp=%0d fn=%0d b=%h c=%h: got res=%h ill=%b, expected res=%h ill=%b",
               tag_of(g, f), g, f, b, c, res, illegal, e[W-1:0], e[W]);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] cs [12];
    for (int i = 0; i < 10; i++) cs[i] = W'(i);
    cs[10] = 8'd16;
    cs[11] = 8'hFF;

    // R1: reset state, with a nonzero request held on the inputs
    grp = 2'd0; fn = 4'd1; opb = 8'hA5; opc = 8'h5A;
    repeat (3) @(negedge clk);
    n_vec++;
    if (res !== '0 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: got res=%h ill=%b, expected res=00 ill=0", res, illegal);
    end
    rst = 1'b0;

    // R1: one-cycle latency, result follows the sampled inputs
    apply(0, 1, 8'hA5, 8'h5A);
    apply(3, 2, 8'hFF, 8'hFF);
    apply(0, 0, 8'hF0, 8'h3C);

    // Boundary cases named by the requirements
    apply(1, 0, 8'h81, 8'd7);   // R5 left, last in-range count
    apply(1, 1, 8'h80, 8'd8);   // R5 right, saturates to sign
    apply(1, 1, 8'h7F, 8'd255); // R5 positive sign saturation
    apply(1, 3, 8'hFF, 8'd8);   // R6 saturation to zero
    apply(1, 5, 8'h00, 8'd3);   // R7 ones from the top
    apply(1, 4, 8'h00, 8'd9);   // R7 saturation to ones
    apply(1, 6, 8'h81, 8'd9);   // R8 count wraps to 1
    apply(1, 7, 8'h01, 8'd16);  // R8 count wraps to 0
    apply(0, 10, 8'hFF, 8'hFF); // R9 first reserved logic code
    apply(1, 8, 8'hFF, 8'd1);   // R9 first reserved shift code
    apply(2, 0, 8'hFF, 8'hFF);  // R9 reserved group

    // Sweep: every group/code pair, 32 operands, 12 counts (R2..R10)
    for (int g = 0; g < 4; g++)
      for (int f = 0; f < 16; f++)
        for (int bi = 0; bi < 32; bi++)
          for (int ci = 0; ci < 12; ci++)
            apply(g, f, W'((bi * 53 + 7 + (bi >> 3) * 128) & 8'hFF), cs[ci]);

    // R1: reset reasserted mid-run clears the outputs
    @(negedge clk);
    grp = 2'd1; fn = 4'd4; opb = 8'h00; opc = 8'd9;
    rst = 1'b1;
    @(negedge clk);
    n_vec++;
    if (res !== '0 || illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset mid-run: got res=%h ill=%b, expected res=00 ill=0", res, illegal);
    end
    finish_run();
  end

endmodule